// File: doc/BRIEF.md
# Token-Count Line Permission Unit

This block decides, for one cache line, whether the local core may read or write it, by counting tokens instead of tracking directory or bus-ordering states. The system has a fixed number of tokens per line (parameter `TOKENS`). A write is legal only while this unit holds every one of them. A read is legal while it holds at least one and has a valid copy of the data. So at any time there is either one writer or any number of readers.

Local loads and stores arrive on an operation port and are held by the requester until `op_done` pulses. When permission is missing, the unit sends one request message (a read request or a write request) and stalls the operation. The operation completes once enough tokens have arrived. Incoming token messages add to the local count in the cycle they are accepted and may carry the line data. Requests from other caches make the unit give tokens away: all of them for a write request, one for a read request. Any outgoing token message carries the data.

Top module: `tok_perm_unit`

## Requirements
- R1: After synchronous reset, the unit holds zero tokens, has no valid data, shows neither read nor write permission, has no outgoing message and no completion, and has the overflow flag clear.
- R2: An accepted message of kind 0 (token grant) adds its `in_tokens` to the count, which is visible on `tokens_held` one cycle later. If `in_has_data` is set, its data becomes the line data.
- R3: If an addition would take the count above `TOKENS`, the count is clamped to `TOKENS` and `overflow_err` rises and stays set until reset.
- R4: A load completes (`op_done` for one cycle, `op_rdata` set to the line data) only when the count is at least one and the line data is valid. `may_read` reports this condition.
- R5: A store completes only when the count equals `TOKENS`. The store writes `op_wdata` into the line, which a later load returns. `may_write` reports this condition.
- R6: An operation without permission sends, one cycle later, a single request message with zero tokens and no data: kind 1 for a load, kind 2 for a store. The request is not repeated while the operation waits.
- R7: An incoming kind 2 (write request) while the count is nonzero produces, one cycle later, a kind 0 message carrying the whole count and the data. The count and data validity drop to zero. With a zero count it produces no message.
- R8: An incoming kind 1 (read request) while the count is two or more produces a kind 0 message with one token and the data, and the count decreases by one. With a count of one or zero it produces no message and the count is unchanged.
- R9: When a reply to another cache and the unit's own request fall in the same cycle, the reply goes out first and the request follows in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Local operation present; held until `op_done` |
| op_store | input | 1 | 1 = store, 0 = load |
| op_wdata | input | DATA_W | Store data |
| op_done | output | 1 | One-cycle completion pulse |
| op_rdata | output | DATA_W | Load result, valid with `op_done` |
| in_valid | input | 1 | Incoming message present |
| in_kind | input | 2 | 0 token grant, 1 read request, 2 write request |
| in_tokens | input | CW | Tokens carried by a grant |
| in_has_data | input | 1 | Grant carries line data |
| in_data | input | DATA_W | Line data of a grant |
| out_valid | output | 1 | Outgoing message present (one cycle) |
| out_kind | output | 2 | Kind of the outgoing message, same encoding |
| out_tokens | output | CW | Tokens carried out |
| out_has_data | output | 1 | Outgoing message carries data |
| out_data | output | DATA_W | Line data sent out |
| tokens_held | output | CW | Current local token count |
| may_read | output | 1 | Read permission |
| may_write | output | 1 | Write permission |
| overflow_err | output | 1 | Sticky count overflow flag |

## Verification
The corner cases targeted are a store stalled on one token short of the full count, which a design that tested "nonzero" instead of "all" would complete early. A read request against a lone token is another: a wrong unit would hand over its last token and lose read permission. A grant that pushes the count past the total must be clamped and flagged, not wrapped to a small value. Finally, an operation's own request must collide with a reply to another cache in the same cycle: a design without ordering would drop one of the two messages, or would repeat its request on every stalled cycle.

// File: rtl/tok_pkg.sv
package tok_pkg;

    // Message kind encoding shared by the in and out ports.
    typedef enum logic [1:0] {
        MK_TOKENS = 2'd0,
        MK_REQ_RD = 2'd1,
        MK_REQ_WR = 2'd2,
        MK_RSVD   = 2'd3
    } msg_kind_e;

    // Bits needed to hold a count from 0 up to total inclusive.
    function automatic int cnt_width(input int total);
        return $clog2(total + 1);
    endfunction

endpackage

// File: rtl/tok_ledger.sv
module tok_ledger #(
    parameter int TOKENS = 8,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          add_en,
    input  logic [CW-1:0] add_n,
    input  logic [CW-1:0] give_n,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_d,
    output logic          overflow_err
);
    logic [CW:0] sum;
    logic        over;

    always_comb begin
        sum = {1'b0, count} - {1'b0, give_n};
        if (add_en) sum = sum + {1'b0, add_n};
        over    = sum > (CW+1)'(TOKENS);
        count_d = over ? CW'(TOKENS) : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count        <= '0;
            overflow_err <= 1'b0;
        end else begin
            count <= count_d;
            if (over) overflow_err <= 1'b1;
        end
    end
endmodule

// File: rtl/tok_access.sv
module tok_access #(
    parameter int TOKENS = 8,
    parameter int CW     = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_store,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic [CW-1:0]     count,
    input  logic [CW-1:0]     count_d,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    output logic              may_read,
    output logic              may_write,
    output logic              op_need,
    output logic              store_now,
    output logic              op_done,
    output logic [DATA_W-1:0] op_rdata,
    output logic [DATA_W-1:0] line_data,
    output logic              line_valid
);
    logic go, permitted, accept;

    always_comb begin
        may_read  = (count != '0) && line_valid;
        may_write = count == CW'(TOKENS);
        permitted = op_store ? may_write : may_read;
        go        = op_valid && !op_done;
        accept    = go && permitted;
        op_need   = go && !permitted;
        store_now = accept && op_store;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_done    <= 1'b0;
            op_rdata   <= '0;
            line_data  <= '0;
            line_valid <= 1'b0;
        end else begin
            op_done <= accept;
            if (accept && !op_store) op_rdata <= line_data;
            if (count_d == '0) begin
                line_valid <= 1'b0;
            end else if (store_now) begin
                line_data  <= op_wdata;
                line_valid <= 1'b1;
            end else if (fill_en) begin
                line_data  <= fill_data;
                line_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tok_msg_port.sv
module tok_msg_port
    import tok_pkg::*;
#(
    parameter int CW     = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  msg_kind_e         in_kind,
    input  logic [CW-1:0]     count,
    input  logic              op_need,
    input  logic              op_store,
    input  logic [DATA_W-1:0] resp_data,
    input  logic              resp_has_data,
    output logic [CW-1:0]     give_n,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [CW-1:0]     out_tokens,
    output logic              out_has_data,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        msg_kind_e         kind;
        logic [CW-1:0]     tokens;
        logic              has_data;
        logic [DATA_W-1:0] data;
    } out_msg_t;

    out_msg_t out_q, out_d;
    logic     pending_q, pending_d;
    logic     resp_wr, resp_rd, resp, send_req;

    always_comb begin
        resp_wr  = in_valid && (in_kind == MK_REQ_WR) && (count != '0);
        resp_rd  = in_valid && (in_kind == MK_REQ_RD) && (int'(count) >= 2);
        resp     = resp_wr || resp_rd;
        give_n   = resp_wr ? count : (resp_rd ? CW'(1) : '0);
        send_req = op_need && !pending_q && !resp;
        out_d    = '0;
        if (resp) begin
            out_d.valid    = 1'b1;
            out_d.kind     = MK_TOKENS;
            out_d.tokens   = give_n;
            out_d.has_data = resp_has_data;
            out_d.data     = resp_has_data ? resp_data : '0;
        end else if (send_req) begin
            out_d.valid = 1'b1;
            out_d.kind  = op_store ? MK_REQ_WR : MK_REQ_RD;
        end
        // A surrender of tokens re-arms the request of a waiting operation.
        pending_d = op_need && !resp && (pending_q || send_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            pending_q <= 1'b0;
        end else begin
            out_q     <= out_d;
            pending_q <= pending_d;
        end
    end

    assign out_valid    = out_q.valid;
    assign out_kind     = out_q.kind;
    assign out_tokens   = out_q.tokens;
    assign out_has_data = out_q.has_data;
    assign out_data     = out_q.data;
endmodule

// File: rtl/tok_perm_unit.sv
module tok_perm_unit
    import tok_pkg::*;
#(
    parameter int TOKENS = 8,
    parameter int DATA_W = 32,
    localparam int CW    = tok_pkg::cnt_width(TOKENS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_store,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              op_done,
    output logic [DATA_W-1:0] op_rdata,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [CW-1:0]     in_tokens,
    input  logic              in_has_data,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [1:0]        out_kind,
    output logic [CW-1:0]     out_tokens,
    output logic              out_has_data,
    output logic [DATA_W-1:0] out_data,
    output logic [CW-1:0]     tokens_held,
    output logic              may_read,
    output logic              may_write,
    output logic              overflow_err
);
    msg_kind_e         kind_in;
    logic              add_en, fill_en;
    logic [CW-1:0]     give_n, count_d;
    logic              op_need, store_now, line_valid;
    logic [DATA_W-1:0] line_data, resp_data;
    logic              resp_has_data;

    always_comb begin
        kind_in       = msg_kind_e'(in_kind);
        add_en        = in_valid && (kind_in == MK_TOKENS);
        fill_en       = add_en && in_has_data;
        resp_data     = store_now ? op_wdata : line_data;
        resp_has_data = store_now || line_valid;
    end

    tok_ledger #(.TOKENS(TOKENS), .CW(CW)) i_ledger (
        .clk(clk), .rst(rst), .add_en(add_en), .add_n(in_tokens),
        .give_n(give_n), .count(tokens_held), .count_d(count_d),
        .overflow_err(overflow_err)
    );

    tok_access #(.TOKENS(TOKENS), .CW(CW), .DATA_W(DATA_W)) i_access (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_store(op_store),
        .op_wdata(op_wdata), .count(tokens_held), .count_d(count_d),
        .fill_en(fill_en), .fill_data(in_data), .may_read(may_read),
        .may_write(may_write), .op_need(op_need), .store_now(store_now),
        .op_done(op_done), .op_rdata(op_rdata), .line_data(line_data),
        .line_valid(line_valid)
    );

    tok_msg_port #(.CW(CW), .DATA_W(DATA_W)) i_msg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(kind_in),
        .count(tokens_held), .op_need(op_need), .op_store(op_store),
        .resp_data(resp_data), .resp_has_data(resp_has_data),
        .give_n(give_n), .out_valid(out_valid), .out_kind(out_kind),
        .out_tokens(out_tokens), .out_has_data(out_has_data),
        .out_data(out_data)
    );
endmodule

// File: rtl/tok_perm_checker.sv
module tok_perm_checker #(
    parameter int TOKENS = 8,
    parameter int CW     = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          op_store,
    input logic          op_done,
    input logic          in_valid,
    input logic [1:0]    in_kind,
    input logic [CW-1:0] in_tokens,
    input logic          out_valid,
    input logic [1:0]    out_kind,
    input logic [CW-1:0] out_tokens,
    input logic          out_has_data,
    input logic [CW-1:0] tokens_held,
    input logic          overflow_err
);
    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        int'(tokens_held) <= TOKENS);

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> overflow_err);

    assert_grant_adds_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd0 && (int'(tokens_held) + int'(in_tokens) <= TOKENS))
        |=> int'(tokens_held) == int'($past(tokens_held)) + int'($past(in_tokens)));

    assert_load_has_token_R4: assert property (@(posedge clk) disable iff (rst)
        op_done |-> $past(tokens_held) != '0);

    assert_store_has_all_R5: assert property (@(posedge clk) disable iff (rst)
        (op_done && $past(op_store)) |-> int'($past(tokens_held)) == TOKENS);

    assert_request_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != 2'd0) |-> (out_tokens == '0 && !out_has_data));

    assert_surrender_all_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd2 && tokens_held != '0)
        |=> (out_valid && out_tokens == $past(tokens_held) && tokens_held == '0));

    assert_share_one_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_kind == 2'd1 && int'(tokens_held) >= 2)
        |=> (out_valid && out_tokens == CW'(1)
             && int'(tokens_held) == int'($past(tokens_held)) - 1));
endmodule

bind tok_perm_unit tok_perm_checker #(.TOKENS(TOKENS), .CW(CW)) i_chk (
    .clk(clk), .rst(rst), .op_store(op_store), .op_done(op_done),
    .in_valid(in_valid), .in_kind(in_kind), .in_tokens(in_tokens),
    .out_valid(out_valid), .out_kind(out_kind), .out_tokens(out_tokens),
    .out_has_data(out_has_data), .tokens_held(tokens_held),
    .overflow_err(overflow_err)
);

// File: tb/test_tok_perm_unit.sv
`timescale 1ns/1ps
module test_tok_perm_unit;
    localparam int T  = 8;
    localparam int DW = 32;
    localparam int CW = $clog2(T + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0, op_store = 1'b0;
    logic [DW-1:0] op_wdata = '0;
    logic op_done;
    logic [DW-1:0] op_rdata;
    logic in_valid = 1'b0, in_has_data = 1'b0;
    logic [1:0] in_kind = 2'd0;
    logic [CW-1:0] in_tokens = '0;
    logic [DW-1:0] in_data = '0;
    logic out_valid, out_has_data, may_read, may_write, overflow_err;
    logic [1:0] out_kind;
    logic [CW-1:0] out_tokens, tokens_held;
    logic [DW-1:0] out_data;

    int n_cmp = 0, n_bad = 0;
    int mcnt;
    logic mvalid;
    logic [DW-1:0] mdata;

    always #5 clk = ~clk;

    tok_perm_unit #(.TOKENS(T), .DATA_W(DW)) i_tok_perm_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_store(op_store),
        .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata),
        .in_valid(in_valid), .in_kind(in_kind), .in_tokens(in_tokens),
        .in_has_data(in_has_data), .in_data(in_data), .out_valid(out_valid),
        .out_kind(out_kind), .out_tokens(out_tokens), .out_has_data(out_has_data),
        .out_data(out_data), .tokens_held(tokens_held), .may_read(may_read),
        .may_write(may_write), .overflow_err(overflow_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int exp_give(input logic [1:0] k, input int cnt);
        if (k == 2'd2) return cnt;
        if (k == 2'd1 && cnt >= 2) return 1;
        return 0;
    endfunction

    function automatic logic exp_read(input int cnt, input logic v);
        return (cnt != 0) && v;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mcnt = 0; mvalid = 1'b0; mdata = '0;
    endtask

    task automatic send_msg(input logic [1:0] k, input int n, input logic hd, input logic [DW-1:0] d);
        in_valid = 1'b1; in_kind = k; in_tokens = CW'(n); in_has_data = hd; in_data = d;
        @(negedge clk);
        in_valid = 1'b0; in_has_data = 1'b0; in_tokens = '0;
    endtask

    task automatic do_op(input logic st, input logic [DW-1:0] wd,
                         output logic done, output logic [DW-1:0] rd);
        op_valid = 1'b1; op_store = st; op_wdata = wd;
        @(negedge clk);
        done = op_done; rd = op_rdata;
        op_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic done;
        logic [DW-1:0] rd;
        int unsigned seed;
        seed = $urandom(32'd7731);

        do_reset();
        // R1 reset state
        check("R1 tokens", tokens_held, 0);
        check("R1 out_valid", out_valid, 0);
        check("R1 op_done", op_done, 0);
        check("R1 err", overflow_err, 0);
        check("R1 may_read", may_read, 0);
        check("R1 may_write", may_write, 0);

        // R6/R4: load with no tokens raises a single read request
        op_valid = 1'b1; op_store = 1'b0;
        @(negedge clk);
        check("R6 req valid", out_valid, 1);
        check("R6 req kind", out_kind, 1);
        check("R6 req tokens", out_tokens, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R6 no repeat", out_valid, 0);
            check("R4 load stalls", op_done, 0);
        end
        send_msg(2'd0, 1, 1'b1, 32'hA5);
        check("R2 count after grant", tokens_held, 1);
        @(negedge clk);
        check("R4 load done", op_done, 1);
        check("R4 load data", op_rdata, 32'hA5);
        op_valid = 1'b0;
        @(negedge clk);

        // R5: store stalls one token short
        op_valid = 1'b1; op_store = 1'b1; op_wdata = 32'h1234;
        @(negedge clk);
        check("R6 store req kind", out_kind, 2);
        check("R6 store req valid", out_valid, 1);
        @(negedge clk);
        check("R5 store stalls", op_done, 0);
        send_msg(2'd0, T - 1, 1'b0, '0);
        check("R2 count full", tokens_held, T);
        check("R5 may_write", may_write, 1);
        @(negedge clk);
        check("R5 store done", op_done, 1);
        op_valid = 1'b0;
        @(negedge clk);
        do_op(1'b0, '0, done, rd);
        check("R5 store visible", rd, 32'h1234);

        // R8/R7: read and write requests from elsewhere
        send_msg(2'd1, 0, 1'b0, '0);
        check("R8 share valid", out_valid, 1);
        check("R8 share tokens", out_tokens, 1);
        check("R8 share data", out_data, 32'h1234);
        check("R8 count", tokens_held, T - 1);
        send_msg(2'd2, 0, 1'b0, '0);
        check("R7 give all", out_tokens, T - 1);
        check("R7 kind", out_kind, 0);
        check("R7 has data", out_has_data, 1);
        check("R7 count zero", tokens_held, 0);
        check("R7 no read", may_read, 0);
        send_msg(2'd2, 0, 1'b0, '0);
        check("R7 nothing to give", out_valid, 0);
        send_msg(2'd0, 1, 1'b1, 32'h77);
        send_msg(2'd1, 0, 1'b0, '0);
        check("R8 keep last", out_valid, 0);
        check("R8 keep count", tokens_held, 1);
        check("R8 still readable", may_read, 1);

        // R3 overflow
        send_msg(2'd0, T, 1'b0, '0);
        check("R3 err", overflow_err, 1);
        check("R3 clamp", tokens_held, T);
        @(negedge clk);
        check("R3 sticky", overflow_err, 1);

        // R9: reply and own request in the same cycle
        do_reset();
        send_msg(2'd0, 2, 1'b1, 32'h55);
        op_valid = 1'b1; op_store = 1'b1; op_wdata = 32'h9;
        send_msg(2'd1, 0, 1'b0, '0);
        check("R9 reply first", out_kind, 0);
        check("R9 reply tokens", out_tokens, 1);
        @(negedge clk);
        check("R9 request next", out_kind, 2);
        check("R9 request valid", out_valid, 1);
        op_valid = 1'b0;
        @(negedge clk);

        // Random mix against the bench model
        do_reset();
        for (int it = 0; it < 400; it++) begin
            int act;
            int n;
            logic hd;
            logic [DW-1:0] d;
            act = int'($urandom % 5);
            d = $urandom;
            case (act)
                0: begin
                    n = int'($urandom % (T - mcnt + 1));
                    hd = 1'($urandom);
                    send_msg(2'd0, n, hd, d);
                    mcnt += n;
                    if (hd) mdata = d;
                    mvalid = (mcnt != 0) && (mvalid || hd);
                    check("R2 rand count", tokens_held, mcnt);
                end
                1, 2: begin
                    logic [1:0] k;
                    int g;
                    k = (act == 1) ? 2'd1 : 2'd2;
                    g = exp_give(k, mcnt);
                    send_msg(k, 0, 1'b0, '0);
                    check(k == 2'd1 ? "R8 rand valid" : "R7 rand valid", out_valid, g != 0);
                    if (g != 0) begin
                        check("R7 rand tokens", out_tokens, g);
                        check("R7 rand has_data", out_has_data, mvalid);
                        if (mvalid) check("R8 rand data", out_data, mdata);
                    end
                    mcnt -= g;
                    if (mcnt == 0) mvalid = 1'b0;
                    check("R7 rand count", tokens_held, mcnt);
                end
                3: if (exp_read(mcnt, mvalid)) begin
                    do_op(1'b0, '0, done, rd);
                    check("R4 rand done", done, 1);
                    check("R4 rand data", rd, mdata);
                end
                default: if (mcnt == T) begin
                    do_op(1'b1, d, done, rd);
                    check("R5 rand done", done, 1);
                    mdata = d; mvalid = 1'b1;
                end
            endcase
            check("R4 rand may_read", may_read, exp_read(mcnt, mvalid));
            check("R5 rand may_write", may_write, mcnt == T);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule